// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM protocol controller. Software asks for a change of state by presenting a three-bit request code with a valid strobe. It then polls an eight-bit status word that gives the current state, the cause of the most recent low-power entry and a sticky error flag. The controller starts in memory initialisation. From there it moves through configuration, normal access and low-power. On the way it stops in named request states while it waits for the datapath to drain, or for the PHY to acknowledge entry into or exit from its low-power mode.

A request that makes no sense in the current state changes nothing, and the error flag records it. When hardware low-power is enabled and the datapath stays idle for long enough in the access state, the block goes to low-power by itself. It marks that entry with trigger value 1. It also leaves that state by itself once traffic returns, so software can leave a hardware-entered low-power state alone. Command scheduling inside the access state and the PHY handshake logic lie outside this block. The PHY side appears here only as acknowledge inputs.

Top module: `mc_opstate_ctrl`

## Requirements
- R1: After reset the status word is 0x00: initialisation state, trigger 0, error flag clear.
- R2: Status bits [2:0] hold the state: 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Bit 3 is the sticky error flag, bits [6:4] the low-power trigger, and bit 7 is always 0.
- R3: The config request code is 1. From init-memory it reaches config at the next edge. From access it enters config-request and stays there until `dp_idle` is high at an edge, then goes to config.
- R4: The go request code is 2. From config it enters access-request for exactly one cycle, then access.
- R5: The sleep request code is 3. From access it enters low-power-entry-request with trigger 2 and stays there until `lp_enter_ack` is high at an edge, then goes to low-power.
- R6: The wakeup request code is 4. From low-power it enters low-power-exit-request and stays there until `lp_exit_ack` is high at an edge, then goes to access, never to config.
- R7: A request for the state already held is a no-op without error: init (code 0) in init-memory, config in config, go in access, sleep in low-power.
- R8: The init request (code 0) from config returns to init-memory. Every other request is illegal: any code from 5 to 7, any request in states 2, 4, 6 or 7, and any pair not listed in R3 to R7. An illegal request leaves the state unchanged and sets the error flag, which stays set until reset.
- R9: With `hw_lp_en` high, `IDLE_CYCLES` consecutive edges in access with `dp_idle` high and no request move the controller to low-power-entry-request with trigger 1. A gap in the condition restarts the count.
- R10: In low-power with trigger 1, a low `dp_idle` or a low `hw_lp_en` moves the controller to low-power-exit-request with no request. With trigger 2 it stays until a wakeup request arrives.
- R11: The trigger field keeps the cause of the last low-power entry, through exit, until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_code | input | 3 | Requested transition code |
| dp_idle | input | 1 | Datapath has no traffic in flight |
| hw_lp_en | input | 1 | Enables hardware-initiated low-power |
| lp_enter_ack | input | 1 | PHY acknowledges low-power entry |
| lp_exit_ack | input | 1 | PHY acknowledges low-power exit |
| status_o | output | 8 | {0, trigger[2:0], error, state[2:0]} |

## Verification
The bench targets the waiting states. A design that moved on without the drain or the acknowledge would show config or low-power one cycle too early. A wakeup that landed in config would show 1 in place of 3. The idle timer is checked one edge before and at expiry, and also across a one-cycle gap in idleness; an off-by-one counter or one that never restarts enters low-power at the wrong edge. Illegal and same-state requests are checked for an unchanged state. A random phase covers error stickiness and the hardware-exit rule: a design that let a software low-power state leave by itself, or that lost the trigger on exit, would disagree with the bench model.

// File: rtl/mc_opstate_pkg.sv
package mc_opstate_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_CFG     = 3'd1,
        ST_CFG_REQ = 3'd2,
        ST_ACC     = 3'd3,
        ST_ACC_REQ = 3'd4,
        ST_LP      = 3'd5,
        ST_LP_ENT  = 3'd6,
        ST_LP_EXT  = 3'd7
    } opstate_e;

    localparam logic [2:0] RQ_INIT  = 3'd0;
    localparam logic [2:0] RQ_CFG   = 3'd1;
    localparam logic [2:0] RQ_GO    = 3'd2;
    localparam logic [2:0] RQ_SLEEP = 3'd3;
    localparam logic [2:0] RQ_WAKE  = 3'd4;

    localparam logic [2:0] TRIG_NONE = 3'd0;
    localparam logic [2:0] TRIG_HW   = 3'd1;
    localparam logic [2:0] TRIG_SW   = 3'd2;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_MOVE    = 2'd1,
        ACT_ILLEGAL = 2'd2
    } req_act_e;

    typedef struct packed {
        opstate_e   state;
        logic [2:0] trig;
        logic       err;
    } ctrl_s;

endpackage

// File: rtl/mc_opstate_legal.sv
module mc_opstate_legal
    import mc_opstate_pkg::*;
(
    input  opstate_e   state_i,
    input  logic       req_valid_i,
    input  logic [2:0] req_code_i,
    output req_act_e   act_o,
    output opstate_e   target_o
);

    always_comb begin
        act_o    = ACT_NONE;
        target_o = state_i;
        if (req_valid_i) begin
            act_o = ACT_ILLEGAL;
            unique case (state_i)
                ST_INIT: begin
                    if (req_code_i == RQ_INIT) begin
                        act_o = ACT_NONE;
                    end else if (req_code_i == RQ_CFG) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_CFG;
                    end
                end
                ST_CFG: begin
                    if (req_code_i == RQ_CFG) begin
                        act_o = ACT_NONE;
                    end else if (req_code_i == RQ_GO) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_ACC_REQ;
                    end else if (req_code_i == RQ_INIT) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_INIT;
                    end
                end
                ST_ACC: begin
                    if (req_code_i == RQ_GO) begin
                        act_o = ACT_NONE;
                    end else if (req_code_i == RQ_CFG) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_CFG_REQ;
                    end else if (req_code_i == RQ_SLEEP) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_LP_ENT;
                    end
                end
                ST_LP: begin
                    if (req_code_i == RQ_SLEEP) begin
                        act_o = ACT_NONE;
                    end else if (req_code_i == RQ_WAKE) begin
                        act_o    = ACT_MOVE;
                        target_o = ST_LP_EXT;
                    end
                end
                default: begin
                    act_o = ACT_ILLEGAL;
                end
            endcase
        end
    end

endmodule

// File: rtl/mc_opstate_idle_timer.sv
module mc_opstate_idle_timer #(
    parameter int IDLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qualify_i,
    output logic expire_o
);

    localparam int CW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = qualify_i && (cnt_q == LAST);
        if (!qualify_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mc_opstate_ctrl.sv
module mc_opstate_ctrl
    import mc_opstate_pkg::*;
#(
    parameter int IDLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_code,
    input  logic       dp_idle,
    input  logic       hw_lp_en,
    input  logic       lp_enter_ack,
    input  logic       lp_exit_ack,
    output logic [7:0] status_o
);

    ctrl_s    ctl_d, ctl_q;
    req_act_e act;
    opstate_e target;
    logic     idle_qual;
    logic     idle_expire;

    mc_opstate_legal u_legal (
        .state_i     (ctl_q.state),
        .req_valid_i (req_valid),
        .req_code_i  (req_code),
        .act_o       (act),
        .target_o    (target)
    );

    assign idle_qual = (ctl_q.state == ST_ACC) && hw_lp_en && dp_idle && !req_valid;

    mc_opstate_idle_timer #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .qualify_i (idle_qual),
        .expire_o  (idle_expire)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_CFG_REQ: if (dp_idle)      ctl_d.state = ST_CFG;
            ST_ACC_REQ:                   ctl_d.state = ST_ACC;
            ST_LP_ENT:  if (lp_enter_ack) ctl_d.state = ST_LP;
            ST_LP_EXT:  if (lp_exit_ack)  ctl_d.state = ST_ACC;
            default: ;
        endcase

        if (act == ACT_ILLEGAL) begin
            ctl_d.err = 1'b1;
        end else if (act == ACT_MOVE) begin
            ctl_d.state = target;
            if (target == ST_LP_ENT) begin
                ctl_d.trig = TRIG_SW;
            end
        end else if (idle_expire) begin
            ctl_d.state = ST_LP_ENT;
            ctl_d.trig  = TRIG_HW;
        end else if ((ctl_q.state == ST_LP) && (ctl_q.trig == TRIG_HW)
                     && (!dp_idle || !hw_lp_en)) begin
            ctl_d.state = ST_LP_EXT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_INIT;
            ctl_q.trig  <= TRIG_NONE;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status_o = {1'b0, ctl_q.trig, ctl_q.err, ctl_q.state};

endmodule

// File: rtl/mc_opstate_chk.sv
module mc_opstate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       dp_idle,
    input logic       lp_enter_ack,
    input logic       lp_exit_ack,
    input logic [7:0] status_o
);

    logic [2:0] st;
    logic [2:0] trig;
    logic       err;
    assign st   = status_o[2:0];
    assign err  = status_o[3];
    assign trig = status_o[6:4];

    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !status_o[7]); // R2
    AST_CFG_REQ_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd2 && !dp_idle) |=> (st == 3'd2)); // R3
    AST_ACC_REQ_ONE: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd4) |=> (st == 3'd3)); // R4
    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd6 && !lp_enter_ack) |=> (st == 3'd6)); // R5
    AST_EXIT_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd7 && lp_exit_ack) |=> (st == 3'd3)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R8
    AST_HW_ENTRY_TRIG: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd3 && !req_valid) |=> (st != 3'd6 || trig == 3'd1)); // R9

endmodule

bind mc_opstate_ctrl mc_opstate_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .dp_idle      (dp_idle),
    .lp_enter_ack (lp_enter_ack),
    .lp_exit_ack  (lp_exit_ack),
    .status_o     (status_o)
);

// File: tb/mc_opstate_ctrl_tb.sv
module mc_opstate_ctrl_tb_top;

    localparam int IDLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_code = 3'd0;
    logic       dp_idle = 1'b0;
    logic       hw_lp_en = 1'b0;
    logic       lp_enter_ack = 1'b0;
    logic       lp_exit_ack = 1'b0;
    logic [7:0] status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mc_opstate_ctrl #(.IDLE_CYCLES(IDLE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_code     (req_code),
        .dp_idle      (dp_idle),
        .hw_lp_en     (hw_lp_en),
        .lp_enter_ack (lp_enter_ack),
        .lp_exit_ack  (lp_exit_ack),
        .status_o     (status_o)
    );

    task automatic chk(input string tag, input logic [7:0] exp);
        n_tests++;
        if (status_o !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual 0x%02h expected 0x%02h", tag, status_o, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [2:0] code);
        @(negedge clk);
        req_valid = 1'b1;
        req_code  = code;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Reference next-state rules written from the requirement list (timer inert).
    function automatic logic [7:0] model(input logic [7:0] s, input logic v, input logic [2:0] c,
                                         input logic idle, input logic hwen,
                                         input logic ea, input logic xa);
        logic [2:0] st = s[2:0];
        logic [2:0] tr = s[6:4];
        logic       er = s[3];
        logic [2:0] nst = st;
        logic       legal = 1'b0;
        logic       moved = 1'b0;
        if (st == 3'd2 && idle) nst = 3'd1;
        if (st == 3'd4)         nst = 3'd3;
        if (st == 3'd6 && ea)   nst = 3'd5;
        if (st == 3'd7 && xa)   nst = 3'd3;
        if (v) begin
            case ({st, c})
                {3'd0, 3'd0}, {3'd1, 3'd1}, {3'd3, 3'd2}, {3'd5, 3'd3}: legal = 1'b1;
                {3'd0, 3'd1}: begin legal = 1'b1; moved = 1'b1; nst = 3'd1; end
                {3'd1, 3'd2}: begin legal = 1'b1; moved = 1'b1; nst = 3'd4; end
                {3'd1, 3'd0}: begin legal = 1'b1; moved = 1'b1; nst = 3'd0; end
                {3'd3, 3'd1}: begin legal = 1'b1; moved = 1'b1; nst = 3'd2; end
                {3'd3, 3'd3}: begin legal = 1'b1; moved = 1'b1; nst = 3'd6; tr = 3'd2; end
                {3'd5, 3'd4}: begin legal = 1'b1; moved = 1'b1; nst = 3'd7; end
                default: legal = 1'b0;
            endcase
            if (!legal) er = 1'b1;
        end
        if (!(v && !legal) && !moved && st == 3'd5 && tr == 3'd1 && (!idle || !hwen))
            nst = 3'd7;
        return {1'b0, tr, er, nst};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_s;
        void'($urandom(32'h5eed_1234));
        tick(3);
        chk("R1 reset", 8'h00);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", 8'h00);

        send(3'd0); chk("R7 init in init", 8'h00);
        send(3'd1); chk("R3 config from init", 8'h01);
        send(3'd1); chk("R7 config in config", 8'h01);
        send(3'd2); chk("R4 access-request", 8'h04);
        tick(1);    chk("R4 access", 8'h03);
        send(3'd2); chk("R7 go in access", 8'h03);

        send(3'd1); chk("R3 config-request", 8'h02);
        tick(3);    chk("R3 waits for drain", 8'h02);
        dp_idle = 1'b1;
        tick(1);    chk("R3 config after drain", 8'h01);
        dp_idle = 1'b0;

        send(3'd0); chk("R8 init from config legal", 8'h00);
        send(3'd1);
        send(3'd2);
        tick(1);    chk("R2 access code", 8'h03);

        send(3'd3); chk("R5 entry-request", 8'h26);
        tick(2);    chk("R5 waits for ack", 8'h26);
        lp_enter_ack = 1'b1;
        tick(1);    chk("R5 low-power sw", 8'h25);
        lp_enter_ack = 1'b0;
        send(3'd3); chk("R7 sleep in low-power", 8'h25);
        tick(3);    chk("R10 sw low-power stays", 8'h25);
        send(3'd4); chk("R6 exit-request", 8'h27);
        tick(2);    chk("R6 waits for ack", 8'h27);
        lp_exit_ack = 1'b1;
        tick(1);    chk("R6 back to access", 8'h23);
        lp_exit_ack = 1'b0;

        hw_lp_en = 1'b1;
        dp_idle  = 1'b1;
        tick(IDLE - 1); chk("R9 before expiry", 8'h23);
        dp_idle = 1'b0;
        tick(1);
        dp_idle = 1'b1;
        tick(IDLE - 1); chk("R9 gap restarts count", 8'h23);
        tick(1);    chk("R9 hw entry trig 1", 8'h16);
        lp_enter_ack = 1'b1;
        tick(1);    chk("R9 hw low-power", 8'h15);
        lp_enter_ack = 1'b0;
        tick(2);    chk("R10 stays while idle", 8'h15);
        dp_idle = 1'b0;
        tick(1);    chk("R10 hw self exit", 8'h17);
        lp_exit_ack = 1'b1;
        tick(1);    chk("R11 trig kept after exit", 8'h13);
        lp_exit_ack = 1'b0;
        hw_lp_en = 1'b0;

        send(3'd4); chk("R8 wakeup in access illegal", 8'h1B);
        send(3'd6); chk("R8 code 6 illegal", 8'h1B);
        tick(2);    chk("R8 error sticky", 8'h1B);

        rst_n = 1'b0;
        tick(1);    chk("R1 reset clears", 8'h00);
        rst_n = 1'b1;
        exp_s = 8'h00;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid    = ($urandom_range(0, 9) < 4);
            req_code     = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
            dp_idle      = $urandom_range(0, 1);
            lp_enter_ack = ($urandom_range(0, 3) == 0);
            lp_exit_ack  = ($urandom_range(0, 3) == 0);
            exp_s = model(exp_s, req_valid, req_code, dp_idle, hw_lp_en, lp_enter_ack, lp_exit_ack);
            @(posedge clk);
            #1;
            chk("R8 random sequence", exp_s);
        end
        req_valid = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule